// File: doc/BRIEF.md
# Division Step Unit

This block carries out a single iteration of a non-restoring binary division. A strobe starts each step. The step takes a partial-remainder word and a divisor word from its inputs. It also uses three flag bits (Q, M, T) that it keeps internally. It returns the updated partial remainder and the new Q and T flags. M holds the divisor's sign, and no step ever changes it.

Q, M and T together carry the add-or-subtract decision and the quotient bit from one step to the next. A control sequencer first issues one of two setup commands:

- Unsigned setup clears all three flags.
- Signed setup loads Q and M from the sign bits of the presented words.

The sequencer then strobes one step per quotient bit and feeds each returned word back as the next input. The quotient bits enter the word through T. For an unsigned 32/16 divide, 16 steps are run with the divisor placed in the upper half. A final left rotate through T then leaves the quotient in the low half.

All results are registered. Step, setup and idle behaviour are fixed for every cycle, so a sequencer can issue one command per clock.

Top module: `divstep_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no command issued, the word output, q_o, m_o, t_o and done_o are all 0.
- R2: An unsigned setup (setup_u_i) clears Q, M and T on the next clock edge.
- R3: A signed setup (setup_s_i) loads Q from bit WIDTH-1 of word_i and M from bit WIDTH-1 of dvs_i, and sets T to Q XOR M. It leaves word_o unchanged and raises no done pulse.
- R4: A step shifts word_i left by one bit and puts the current T into bit 0. It subtracts dvs_i from the shifted word when the current Q equals M, and adds dvs_i otherwise. The WIDTH-bit result appears on word_o.
- R5: After a step, Q equals bit WIDTH-1 of the pre-shift word_i XOR the add carry-out (or the subtract borrow) XOR M.
- R6: After a step, T is 1 when the new Q equals M and 0 otherwise.
- R7: A step leaves M unchanged.
- R8: Step results and done_o are valid one clock after the strobe. done_o is high for exactly that one cycle. With no command present, word_o and all flags hold their values.
- R9: When commands coincide, unsigned setup wins over signed setup, and signed setup wins over step. Only the winning command acts, and done_o pulses only when a step wins.
- R10: Start with an unsigned setup and a dividend whose upper half is below a nonzero 16-bit divisor. Run 16 chained steps with the divisor shifted into the upper half of dvs_i. Then take bits [15:0] of {word_o[WIDTH-2:0], t_o}. These bits equal the unsigned quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Strobe for one division step |
| setup_u_i | input | 1 | Unsigned setup command (clear flags) |
| setup_s_i | input | 1 | Signed setup command (load flags from sign bits) |
| word_i | input | WIDTH | Partial remainder for a step; dividend for signed setup |
| dvs_i | input | WIDTH | Divisor |
| word_o | output | WIDTH | Registered partial remainder from the last step |
| q_o | output | 1 | Q flag |
| m_o | output | 1 | M flag (divisor sign) |
| t_o | output | 1 | T flag (quotient bit / carry into next shift) |
| done_o | output | 1 | One-cycle pulse when step results are valid |

## Verification
Every result (word_o, the three flags and done_o) is due exactly one rising edge after the command that produced it, and only steps pulse done_o. The bench changes inputs on the falling edge and holds them for one full period. It then clears them and samples on the next falling edge, half a period after the register update. The hold checks sample two further falling edges later, to confirm that nothing moves when no command is present. The chained-division checks feed each sampled word_o back as the next word_i, so every step sees the registered state of the step before it.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   // Command chosen for the current cycle after priority resolution
   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_STEP    = 2'd1,
      CMD_SETUP_S = 2'd2,
      CMD_SETUP_U = 2'd3
   } divstep_cmd_e;

   // Status flags kept between steps
   typedef struct packed {
      logic q;
      logic m;
      logic t;
   } divstep_flags_t;

endpackage

// File: rtl/divstep_cmd_arb.sv
module divstep_cmd_arb
   import divstep_pkg::*;
(
   input  logic         setup_u_i,
   input  logic         setup_s_i,
   input  logic         step_i,
   output divstep_cmd_e cmd_o
);

   // Fixed priority: unsigned setup, then signed setup, then step
   always_comb begin
      if (setup_u_i)      cmd_o = CMD_SETUP_U;
      else if (setup_s_i) cmd_o = CMD_SETUP_S;
      else if (step_i)    cmd_o = CMD_STEP;
      else                cmd_o = CMD_NONE;
   end

endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
   parameter int WIDTH        = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] word_i,
   input  logic [WIDTH-1:0] dvs_i,
   input  logic             t_in,
   input  logic             do_sub,
   output logic [WIDTH-1:0] res_o,
   output logic             cb_o,
   output logic             msb_o
);

   logic [WIDTH-1:0] shifted;

   // Bit shifted out is reported before the shift; T enters at the bottom
   assign msb_o   = word_i[WIDTH-1];
   assign shifted = {word_i[WIDTH-2:0], t_in};

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder; subtraction as add of inverted operand plus one
         logic [WIDTH-1:0] opnd;
         logic [WIDTH:0]   total;
         assign opnd  = do_sub ? ~dvs_i : dvs_i;
         assign total = {1'b0, shifted} + {1'b0, opnd} + {{WIDTH{1'b0}}, do_sub};
         assign res_o = total[WIDTH-1:0];
         // Borrow is the inverse of the carry of the complemented add
         assign cb_o  = do_sub ? ~total[WIDTH] : total[WIDTH];
      end else begin : g_split
         // Separate adder and subtractor, result chosen afterwards
         logic [WIDTH:0] sum_add;
         logic [WIDTH:0] sum_sub;
         assign sum_add = {1'b0, shifted} + {1'b0, dvs_i};
         assign sum_sub = {1'b0, shifted} - {1'b0, dvs_i};
         assign res_o   = do_sub ? sum_sub[WIDTH-1:0] : sum_add[WIDTH-1:0];
         assign cb_o    = do_sub ? sum_sub[WIDTH] : sum_add[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/divstep_flag_calc.sv
module divstep_flag_calc
   import divstep_pkg::*;
(
   input  divstep_cmd_e   cmd_i,
   input  divstep_flags_t cur_i,
   input  logic           word_msb_i,
   input  logic           dvs_msb_i,
   input  logic           cb_i,
   output divstep_flags_t nxt_o
);

   always_comb begin
      nxt_o = cur_i;
      unique case (cmd_i)
         CMD_SETUP_U: begin
            nxt_o = '0;
         end
         CMD_SETUP_S: begin
            nxt_o.q = word_msb_i;
            nxt_o.m = dvs_msb_i;
            nxt_o.t = word_msb_i ^ dvs_msb_i;
         end
         CMD_STEP: begin
            // One expression covers all four old-Q / M combinations
            nxt_o.q = word_msb_i ^ cb_i ^ cur_i.m;
            nxt_o.t = (word_msb_i ^ cb_i ^ cur_i.m) == cur_i.m;
         end
         default: begin
            nxt_o = cur_i;
         end
      endcase
   end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             setup_u_i,
   input  logic             setup_s_i,
   input  logic [WIDTH-1:0] word_i,
   input  logic [WIDTH-1:0] dvs_i,
   output logic [WIDTH-1:0] word_o,
   output logic             q_o,
   output logic             m_o,
   output logic             t_o,
   output logic             done_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("divstep_unit: WIDTH must be at least 2");
      end
   endgenerate

   divstep_cmd_e   cmd;
   divstep_flags_t flags_q;
   divstep_flags_t flags_nxt;
   logic [MSB:0]   word_q;
   logic [MSB:0]   alu_res;
   logic           alu_cb;
   logic           word_msb;
   logic           done_q;
   logic           do_sub;

   divstep_cmd_arb u_arb (
      .setup_u_i (setup_u_i),
      .setup_s_i (setup_s_i),
      .step_i    (step_i),
      .cmd_o     (cmd)
   );

   // Subtract when the old Q matches M
   assign do_sub = (flags_q.q == flags_q.m);

   divstep_addsub #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_addsub (
      .word_i (word_i),
      .dvs_i  (dvs_i),
      .t_in   (flags_q.t),
      .do_sub (do_sub),
      .res_o  (alu_res),
      .cb_o   (alu_cb),
      .msb_o  (word_msb)
   );

   divstep_flag_calc u_flags (
      .cmd_i      (cmd),
      .cur_i      (flags_q),
      .word_msb_i (word_msb),
      .dvs_msb_i  (dvs_i[MSB]),
      .cb_i       (alu_cb),
      .nxt_o      (flags_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         flags_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (cmd == CMD_STEP);
         if (cmd != CMD_NONE) flags_q <= flags_nxt;
         if (cmd == CMD_STEP) word_q  <= alu_res;
      end
   end

   assign word_o = word_q;
   assign q_o    = flags_q.q;
   assign m_o    = flags_q.m;
   assign t_o    = flags_q.t;
   assign done_o = done_q;

endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_i,
   input logic             setup_u_i,
   input logic             setup_s_i,
   input logic [WIDTH-1:0] word_i,
   input logic [WIDTH-1:0] dvs_i,
   input logic [WIDTH-1:0] word_o,
   input logic             q_o,
   input logic             m_o,
   input logic             t_o,
   input logic             done_o
);

   logic step_only;
   logic sset_only;
   logic idle;

   assign step_only = step_i && !setup_u_i && !setup_s_i;
   assign sset_only = setup_s_i && !setup_u_i;
   assign idle      = !step_i && !setup_u_i && !setup_s_i;

   a_r2_unsigned_clear: assert property (@(posedge clk) disable iff (!rst_n)
      setup_u_i |=> (!q_o && !m_o && !t_o));

   a_r3_signed_load: assert property (@(posedge clk) disable iff (!rst_n)
      sset_only |=> (q_o == $past(word_i[WIDTH-1])) && (m_o == $past(dvs_i[WIDTH-1]))
                    && (t_o == (q_o ^ m_o)) && !done_o && $stable(word_o));

   a_r6_t_tracks_q: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (t_o == (q_o == m_o)));

   a_r7_m_kept: assert property (@(posedge clk) disable iff (!rst_n)
      step_only |=> $stable(m_o));

   a_r8_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_only |=> done_o);

   a_r9_no_done_on_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_u_i || setup_s_i) |=> !done_o);

   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> ($stable(word_o) && $stable(q_o) && $stable(m_o) && $stable(t_o) && !done_o));

endmodule

bind divstep_unit divstep_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_i    (step_i),
   .setup_u_i (setup_u_i),
   .setup_s_i (setup_s_i),
   .word_i    (word_i),
   .dvs_i     (dvs_i),
   .word_o    (word_o),
   .q_o       (q_o),
   .m_o       (m_o),
   .t_o       (t_o),
   .done_o    (done_o)
);

// File: tb/divstep_unit_bench.sv
`timescale 1ns/1ps
module divstep_unit_bench;

   localparam int W = 32;

   typedef struct packed {
      logic         sgn;
      logic [W-1:0] sa;
      logic [W-1:0] sb;
      logic [W-1:0] w;
      logic [W-1:0] d;
      logic [W-1:0] ew;
      logic         eq;
      logic         et;
   } vec_t;

   // Setup kind/words, step inputs, expected word, Q, T
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0,        32'h0,        32'h00000010, 32'h00000005, 32'h0000001B, 1'b0, 1'b1},
      '{1'b0, 32'h0,        32'h0,        32'h00000001, 32'h00000005, 32'hFFFFFFFD, 1'b1, 1'b0},
      '{1'b1, 32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b0, 1'b1},
      '{1'b1, 32'h80000000, 32'h00000001, 32'h80000000, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
      '{1'b1, 32'h00000001, 32'hC0000000, 32'h40000000, 32'hC0000000, 32'h40000001, 1'b0, 1'b0},
      '{1'b1, 32'h00000001, 32'hC0000000, 32'h80000001, 32'h00000001, 32'h00000004, 1'b0, 1'b0},
      '{1'b1, 32'h80000000, 32'h80000000, 32'h00000003, 32'h00000007, 32'hFFFFFFFF, 1'b0, 1'b0},
      '{1'b1, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0},
      '{1'b1, 32'h80000000, 32'h80000000, 32'hC0000000, 32'hFFFFFFF0, 32'h80000010, 1'b1, 1'b1},
      '{1'b0, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         step_i = 1'b0;
   logic         setup_u_i = 1'b0;
   logic         setup_s_i = 1'b0;
   logic [W-1:0] word_i = '0;
   logic [W-1:0] dvs_i = '0;
   logic [W-1:0] word_o;
   logic         q_o, m_o, t_o, done_o;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   divstep_unit #(.WIDTH(W)) u_divstep_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step_i),
      .setup_u_i (setup_u_i),
      .setup_s_i (setup_s_i),
      .word_i    (word_i),
      .dvs_i     (dvs_i),
      .word_o    (word_o),
      .q_o       (q_o),
      .m_o       (m_o),
      .t_o       (t_o),
      .done_o    (done_o)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive a command for one cycle, then sample on the following falling edge
   task automatic issue(input bit su, input bit ss, input bit st,
                        input logic [W-1:0] w, input logic [W-1:0] d);
      @(negedge clk);
      setup_u_i = su; setup_s_i = ss; step_i = st; word_i = w; dvs_i = d;
      @(negedge clk);
      setup_u_i = 1'b0; setup_s_i = 1'b0; step_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog R8: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] keep;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 word in reset", word_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 word", word_o, '0);
      check("R1 flags", W'({q_o, m_o, t_o}), '0);
      check("R1 done", W'(done_o), '0);

      // Table walk: setup, then one step (R4, R5, R6, R7, R8)
      for (int i = 0; i < NV; i++) begin
         logic exp_m;
         exp_m = VECS[i].sgn ? VECS[i].sb[W-1] : 1'b0;
         if (VECS[i].sgn) issue(1'b0, 1'b1, 1'b0, VECS[i].sa, VECS[i].sb);
         else             issue(1'b1, 1'b0, 1'b0, '0, '0);
         issue(1'b0, 1'b0, 1'b1, VECS[i].w, VECS[i].d);
         check($sformatf("R4 word vec%0d", i), word_o, VECS[i].ew);
         check($sformatf("R5 q vec%0d", i), W'(q_o), W'(VECS[i].eq));
         check($sformatf("R6 t vec%0d", i), W'(t_o), W'(VECS[i].et));
         check($sformatf("R7 m vec%0d", i), W'(m_o), W'(exp_m));
         check($sformatf("R8 done vec%0d", i), W'(done_o), W'(1'b1));
      end

      // R8: hold and single-cycle done
      keep = word_o;
      @(negedge clk);
      check("R8 done drops", W'(done_o), '0);
      @(negedge clk);
      check("R8 word holds", word_o, keep);

      // R3: signed setup loads signs, word unchanged, no done
      issue(1'b0, 1'b1, 1'b0, 32'h80000000, 32'h00001234);
      check("R3 q", W'(q_o), W'(1'b1));
      check("R3 m", W'(m_o), W'(1'b0));
      check("R3 t", W'(t_o), W'(1'b1));
      check("R3 word kept", word_o, keep);
      check("R3 no done", W'(done_o), '0);

      // R2: unsigned setup clears a nonzero flag set
      issue(1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      check("R2 flags clear", W'({q_o, m_o, t_o}), '0);

      // R9: all three at once -> unsigned setup only
      issue(1'b0, 1'b1, 1'b0, 32'h80000000, 32'h80000000);
      issue(1'b1, 1'b1, 1'b1, 32'h00000005, 32'h00000001);
      check("R9 all flags clear", W'({q_o, m_o, t_o}), '0);
      check("R9 all no done", W'(done_o), '0);
      check("R9 all word kept", word_o, keep);
      // R9: signed setup and step together -> signed setup only
      issue(1'b0, 1'b1, 1'b1, 32'h00000005, 32'h80000000);
      check("R9 ss q/m/t", W'({q_o, m_o, t_o}), W'(3'b011));
      check("R9 ss no done", W'(done_o), '0);
      check("R9 ss word kept", word_o, keep);

      // R10: chained unsigned 32/16 divide
      for (int k = 0; k < 24; k++) begin
         logic [15:0]  d16, hi, lo, quo;
         logic [W-1:0] num, cur;
         d16 = 16'(($urandom % 65535) + 1);
         if (k == 0) d16 = 16'h0001;
         if (k == 1) d16 = 16'hFFFF;
         hi  = 16'($urandom % d16);
         lo  = 16'($urandom);
         if (k == 1) begin hi = 16'hFFFE; lo = 16'hFFFF; end
         num = {hi, lo};
         issue(1'b1, 1'b0, 1'b0, '0, '0);
         cur = num;
         for (int s = 0; s < 16; s++) begin
            issue(1'b0, 1'b0, 1'b1, cur, {d16, 16'h0000});
            cur = word_o;
         end
         quo = 16'({cur[W-2:0], t_o});
         check($sformatf("R10 quotient %h/%h", num, d16), W'(quo), W'(num / W'(d16)));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule